// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block steers the flow of instruction groups through a superscalar rename stage. Each cycle decode offers a group of up to `WIDTH` instructions. Each instruction carries a "killed" flag and a count of the destination registers it needs. The controller sets how many of them may move on. That limit comes from three things: the reorder-buffer credit, the issue-queue credit and the number of free physical registers. It reports which group slots were forwarded and how many registers were taken from the free pool. The register map itself lives outside the block, which only hands it a grant count.

The ROB and issue-queue credits arrive `DELAY` cycles late. To cover this, the controller keeps `WIDTH*DELAY` entries of each in reserve. When a group cannot be finished, the whole group goes into a small skid FIFO, together with the slot index at which work resumes. The stage then raises a stall toward decode and drains the FIFO before it runs freely again. A squash from commit clears all pending work at once.

Top module: `rename_stall_ctrl`

## Requirements
- R1: The usable ROB credit is `rob_free - WIDTH*DELAY` and the usable issue-queue credit is `iq_free - WIDTH*DELAY`. At most min(usable ROB, usable IQ) slots are consumed in a cycle. When that minimum is zero or below, nothing is forwarded and the group is held.
- R2: Slots are examined in increasing index, starting from the resume offset (0 for a fresh group). `fwd_mask` bit i is set when slot i is forwarded this cycle.
- R3: A killed slot (`dec_kill` bit i = 1) is never forwarded. It still consumes one unit of the slot budget and moves the resume point past it.
- R4: `reg_grant` equals the sum of the destination counts of the forwarded slots. Slot i's count is the field `dec_ndst[i*DST_W +: DST_W]`. Forwarding stops at the first live slot whose count exceeds the registers still free, and no later slot of the group goes out that cycle.
- R5: In Running, a group that is not finished is stored in the skid FIFO with its resume offset, and the next state is Blocked. `stall_dec` is 1 exactly in Blocked and Unblocking. `stage_state` is encoded as Running=0, Blocked=1, Unblocking=2, Squashing=3.
- R6: In Running, a high `down_stall` forwards nothing, stores the incoming group (if `dec_cnt` > 0) and moves the stage to Blocked.
- R7: In Blocked, every incoming group with `dec_cnt` > 0 is appended to the skid FIFO. The stage leaves Blocked only when `down_stall` is low, both usable credits are positive and `reg_free` is nonzero. It then moves to Unblocking, or straight to Running if the FIFO is empty.
- R8: In Unblocking, the oldest skid entry is processed from its stored offset, with `fwd_from_skid` = 1. A finished entry is removed, and the stage returns to Running once the FIFO is empty. An unfinished entry keeps its new offset and the stage goes back to Blocked. A high `down_stall` in Unblocking forwards nothing and moves the stage to Blocked.
- R9: A high `squash` forwards nothing, empties the skid FIFO and moves the stage to Squashing. A Squashing cycle without `squash` handles the decode group exactly as Running does.
- R10: `skid_err` rises when a group arrives while the skid FIFO is full and nothing leaves that cycle. It then stays 1 until reset.
- R11: After reset, the stage is in Running with an empty skid FIFO, `stall_dec` = 0, `skid_err` = 0 and no slot forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_cnt | input | BW | Number of valid slots in the decode group (0 = none) |
| dec_kill | input | WIDTH | Per-slot killed flag |
| dec_ndst | input | WIDTH*DST_W | Per-slot destination register count |
| rob_free | input | CNT_W | Reported free ROB entries (delayed) |
| iq_free | input | CNT_W | Reported free issue-queue entries (delayed) |
| reg_free | input | REG_W | Free physical registers |
| down_stall | input | 1 | Stall from a later stage |
| squash | input | 1 | Squash request from commit |
| fwd_mask | output | WIDTH | Slots of the current group forwarded this cycle |
| fwd_from_skid | output | 1 | The current group comes from the skid FIFO |
| reg_grant | output | GR_W | Registers taken from the free pool this cycle |
| stall_dec | output | 1 | Stall toward decode |
| stage_state | output | 2 | Current state (encoding in R5) |
| skid_err | output | 1 | Sticky skid FIFO overflow flag |

## Verification
The slot walk is swept over every group size and every killed-slot pattern. Each of these is combined with credit levels from below zero to above the width, and with register pools from empty to ample. Together they separate the effects of the credit ceiling, of skipped killed slots using up budget, and of the register-shortage stop.

Directed sequences then cover the rest. One resumes a partly renamed group from the skid FIFO. Another drains two queued groups in order. A third resumes after a register shortage inside Unblocking. Others cover an issue-queue-limited budget, overflow and a squash. The sequences show that the stored offset, the FIFO order and the clear-on-squash behave as intended.

// File: rtl/rename_ctl_pkg.sv
package rename_ctl_pkg;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_BLK = 2'd1,
    ST_UNB = 2'd2,
    ST_SQ  = 2'd3
  } rn_state_e;

endpackage

// File: rtl/rename_credit.sv
// Converts delayed free counts into a slot budget for this cycle.
module rename_credit #(
  parameter int WIDTH = 4,
  parameter int DELAY = 1,
  parameter int CNT_W = 6,
  parameter int BW    = 3
) (
  input  logic [CNT_W-1:0] rob_free,
  input  logic [CNT_W-1:0] iq_free,
  output logic [BW-1:0]    budget,
  output logic             open
);

  localparam int SW   = CNT_W + 2;
  localparam int RESV = WIDTH * DELAY;

  logic signed [SW-1:0] rob_use;
  logic signed [SW-1:0] iq_use;
  logic signed [SW-1:0] low;

  always_comb begin
    rob_use = $signed({2'b00, rob_free}) - $signed(SW'(RESV));
    iq_use  = $signed({2'b00, iq_free})  - $signed(SW'(RESV));
    low     = (rob_use < iq_use) ? rob_use : iq_use;
    open    = !low[SW-1] && (low != '0);
    if (!open) begin
      budget = '0;
    end else if (low > $signed(SW'(WIDTH))) begin
      budget = BW'(WIDTH);
    end else begin
      budget = low[BW-1:0];
    end
  end

endmodule

// File: rtl/rename_group_walk.sv
// Walks the slots of one group from a resume offset, in order.
module rename_group_walk #(
  parameter int WIDTH = 4,
  parameter int DST_W = 2,
  parameter int REG_W = 6,
  parameter int BW    = 3,
  parameter int GR_W  = 4
) (
  input  logic [BW-1:0]          cnt,
  input  logic [WIDTH-1:0]       kill,
  input  logic [WIDTH*DST_W-1:0] ndst,
  input  logic [BW-1:0]          off,
  input  logic [BW-1:0]          budget,
  input  logic [REG_W-1:0]       reg_free,
  output logic [WIDTH-1:0]       fwd,
  output logic [BW-1:0]          new_off,
  output logic                   done,
  output logic [GR_W-1:0]        grant
);

  logic [REG_W-1:0] left;
  logic [BW-1:0]    taken;
  logic             go;
  logic [DST_W-1:0] need;

  always_comb begin
    fwd     = '0;
    new_off = off;
    grant   = '0;
    left    = reg_free;
    taken   = '0;
    go      = 1'b1;
    need    = '0;
    for (int i = 0; i < WIDTH; i++) begin
      need = ndst[i*DST_W +: DST_W];
      if (go && (BW'(i) >= off) && (BW'(i) < cnt)) begin
        if (taken >= budget) begin
          go = 1'b0;
        end else if (kill[i]) begin
          taken   = taken + 1'b1;
          new_off = BW'(i + 1);
        end else if (REG_W'(need) > left) begin
          go = 1'b0;
        end else begin
          fwd[i]  = 1'b1;
          left    = left - REG_W'(need);
          grant   = grant + GR_W'(need);
          taken   = taken + 1'b1;
          new_off = BW'(i + 1);
        end
      end
    end
    done = (new_off >= cnt);
  end

endmodule

// File: rtl/rename_skid_fifo.sv
// Whole-group FIFO; each entry carries its own resume offset.
module rename_skid_fifo #(
  parameter int DEPTH = 2,
  parameter int WIDTH = 4,
  parameter int DST_W = 2,
  parameter int BW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   push,
  input  logic [BW-1:0]          push_cnt,
  input  logic [WIDTH-1:0]       push_kill,
  input  logic [WIDTH*DST_W-1:0] push_ndst,
  input  logic [BW-1:0]          push_off,
  input  logic                   pop,
  input  logic                   upd,
  input  logic [BW-1:0]          upd_off,
  output logic [BW-1:0]          head_cnt,
  output logic [WIDTH-1:0]       head_kill,
  output logic [WIDTH*DST_W-1:0] head_ndst,
  output logic [BW-1:0]          head_off,
  output logic                   empty,
  output logic                   last,
  output logic                   ovf_err
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [BW-1:0]          cnt_m  [DEPTH];
  logic [WIDTH-1:0]       kill_m [DEPTH];
  logic [WIDTH*DST_W-1:0] ndst_m [DEPTH];
  logic [BW-1:0]          off_m  [DEPTH];

  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] num_q, num_d;
  logic          err_d;
  logic          full, acc, ovf;

  always_comb begin
    full  = (num_q == CW'(DEPTH));
    acc   = push && (!full || pop);
    ovf   = push && full && !pop;
    rd_d  = rd_q;
    wr_d  = wr_q;
    num_d = num_q;
    err_d = ovf_err | ovf;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      num_d = '0;
    end else begin
      if (acc) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop) rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      num_d = num_q + CW'(acc) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      num_q   <= '0;
      ovf_err <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      num_q   <= num_d;
      ovf_err <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd && !clr) off_m[rd_q] <= upd_off;
    if (acc && !clr) begin
      cnt_m[wr_q]  <= push_cnt;
      kill_m[wr_q] <= push_kill;
      ndst_m[wr_q] <= push_ndst;
      off_m[wr_q]  <= push_off;
    end
  end

  assign head_cnt  = cnt_m[rd_q];
  assign head_kill = kill_m[rd_q];
  assign head_ndst = ndst_m[rd_q];
  assign head_off  = off_m[rd_q];
  assign empty     = (num_q == '0);
  assign last      = (num_q == CW'(1));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(push && full && !pop));

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    num_q <= CW'(DEPTH));

endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
  import rename_ctl_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int DELAY      = 1,
  parameter int SKID_DEPTH = 2,
  parameter int CNT_W      = 6,
  parameter int DST_W      = 2,
  parameter int REG_W      = 6,
  localparam int BW        = $clog2(WIDTH + 1),
  localparam int GR_W      = $clog2(WIDTH * ((1 << DST_W) - 1) + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BW-1:0]          dec_cnt,
  input  logic [WIDTH-1:0]       dec_kill,
  input  logic [WIDTH*DST_W-1:0] dec_ndst,
  input  logic [CNT_W-1:0]       rob_free,
  input  logic [CNT_W-1:0]       iq_free,
  input  logic [REG_W-1:0]       reg_free,
  input  logic                   down_stall,
  input  logic                   squash,
  output logic [WIDTH-1:0]       fwd_mask,
  output logic                   fwd_from_skid,
  output logic [GR_W-1:0]        reg_grant,
  output logic                   stall_dec,
  output logic [1:0]             stage_state,
  output logic                   skid_err
);

  rn_state_e st_q, st_d;

  logic [BW-1:0]          budget;
  logic                   credit_open;
  logic [BW-1:0]          sk_cnt, sk_off;
  logic [WIDTH-1:0]       sk_kill;
  logic [WIDTH*DST_W-1:0] sk_ndst;
  logic                   sk_empty, sk_last;
  logic                   from_skid;
  logic [BW-1:0]          src_cnt, src_off;
  logic [WIDTH-1:0]       src_kill;
  logic [WIDTH*DST_W-1:0] src_ndst;
  logic [WIDTH-1:0]       w_fwd;
  logic [BW-1:0]          w_off;
  logic                   w_done;
  logic [GR_W-1:0]        w_grant;
  logic                   push, pop, clr, upd, proc;
  logic [BW-1:0]          push_off;

  rename_credit #(
    .WIDTH(WIDTH), .DELAY(DELAY), .CNT_W(CNT_W), .BW(BW)
  ) u_credit (
    .rob_free(rob_free), .iq_free(iq_free), .budget(budget), .open(credit_open)
  );

  assign from_skid = (st_q == ST_UNB);
  assign src_cnt   = from_skid ? sk_cnt  : dec_cnt;
  assign src_kill  = from_skid ? sk_kill : dec_kill;
  assign src_ndst  = from_skid ? sk_ndst : dec_ndst;
  assign src_off   = from_skid ? sk_off  : '0;

  rename_group_walk #(
    .WIDTH(WIDTH), .DST_W(DST_W), .REG_W(REG_W), .BW(BW), .GR_W(GR_W)
  ) u_walk (
    .cnt(src_cnt), .kill(src_kill), .ndst(src_ndst), .off(src_off),
    .budget(budget), .reg_free(reg_free),
    .fwd(w_fwd), .new_off(w_off), .done(w_done), .grant(w_grant)
  );

  rename_skid_fifo #(
    .DEPTH(SKID_DEPTH), .WIDTH(WIDTH), .DST_W(DST_W), .BW(BW)
  ) u_skid (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(push), .push_cnt(dec_cnt), .push_kill(dec_kill),
    .push_ndst(dec_ndst), .push_off(push_off),
    .pop(pop), .upd(upd), .upd_off(w_off),
    .head_cnt(sk_cnt), .head_kill(sk_kill), .head_ndst(sk_ndst),
    .head_off(sk_off), .empty(sk_empty), .last(sk_last), .ovf_err(skid_err)
  );

  // Next-state and skid control.
  always_comb begin
    st_d     = st_q;
    push     = 1'b0;
    pop      = 1'b0;
    clr      = 1'b0;
    upd      = 1'b0;
    push_off = '0;
    if (squash) begin
      clr  = 1'b1;
      st_d = ST_SQ;
    end else begin
      unique case (st_q)
        ST_RUN, ST_SQ: begin
          if (down_stall) begin
            push = (dec_cnt != '0);
            st_d = ST_BLK;
          end else if (!w_done) begin
            push     = 1'b1;
            push_off = w_off;
            st_d     = ST_BLK;
          end else begin
            st_d = ST_RUN;
          end
        end
        ST_BLK: begin
          push = (dec_cnt != '0);
          if (!down_stall && credit_open && (reg_free != '0)) begin
            st_d = (sk_empty && !push) ? ST_RUN : ST_UNB;
          end
        end
        ST_UNB: begin
          push = (dec_cnt != '0);
          if (down_stall) begin
            st_d = ST_BLK;
          end else if (w_done) begin
            pop = 1'b1;
            if (sk_last && !push) st_d = ST_RUN;
          end else begin
            upd  = 1'b1;
            st_d = ST_BLK;
          end
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign proc          = !squash && !down_stall && (st_q != ST_BLK);
  assign fwd_mask      = proc ? w_fwd : '0;
  assign reg_grant     = proc ? w_grant : '0;
  assign fwd_from_skid = proc && from_skid;
  assign stall_dec     = (st_q == ST_BLK) || (st_q == ST_UNB);
  assign stage_state   = st_q;

  assert_budget_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fwd_mask) <= int'(budget));

  assert_no_killed_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mask & src_kill) == '0);

  assert_grant_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(reg_grant) <= int'(reg_free));

  assert_run_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |-> sk_empty);

  assert_unblock_has_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UNB) |-> !sk_empty);

  assert_squash_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (st_q == ST_SQ) && sk_empty);

endmodule

// File: tb/rename_stall_ctrl_bench.sv
module rename_stall_ctrl_bench;

  localparam int WIDTH = 4;
  localparam int BW    = 3;
  localparam int GR_W  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [BW-1:0]  dec_cnt;
  logic [WIDTH-1:0] dec_kill;
  logic [7:0]     dec_ndst;
  logic [5:0]     rob_free, iq_free, reg_free;
  logic           down_stall, squash;
  logic [WIDTH-1:0] fwd_mask;
  logic           fwd_from_skid;
  logic [GR_W-1:0] reg_grant;
  logic           stall_dec;
  logic [1:0]     stage_state;
  logic           skid_err;

  int checks = 0;
  int errors = 0;

  // Slot register needs: slot0=1, slot1=2, slot2=0, slot3=1
  localparam int ND = 73;

  always #2 clk = ~clk;

  rename_stall_ctrl u_rename_stall_ctrl (
    .clk(clk), .rst_n(rst_n), .dec_cnt(dec_cnt), .dec_kill(dec_kill),
    .dec_ndst(dec_ndst), .rob_free(rob_free), .iq_free(iq_free),
    .reg_free(reg_free), .down_stall(down_stall), .squash(squash),
    .fwd_mask(fwd_mask), .fwd_from_skid(fwd_from_skid), .reg_grant(reg_grant),
    .stall_dec(stall_dec), .stage_state(stage_state), .skid_err(skid_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int c, input int k, input int rob, input int iq,
                       input int rg, input int ds, input int sq);
    dec_cnt    = BW'(c);
    dec_kill   = WIDTH'(k);
    dec_ndst   = 8'(ND);
    rob_free   = 6'(rob);
    iq_free    = 6'(iq);
    reg_free   = 6'(rg);
    down_stall = ds[0];
    squash     = sq[0];
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Expected slot walk, written from R1-style budget, R3 skip and R4 stop rules.
  function automatic void expect_walk(input int c, input int k, input int bud,
                                      input int regs, input int start,
                                      output int m, output int g, output int noff);
    int p;
    int used;
    int need;
    int lim;
    p = start; used = 0; m = 0; g = 0;
    lim = (bud < 0) ? 0 : bud;
    while (p < c && used < lim) begin
      need = (ND >> (2 * p)) & 3;
      if (((k >> p) & 1) == 1) begin
        p++; used++;
      end else if (need > regs) begin
        break;
      end else begin
        m = m | (1 << p); regs = regs - need; g = g + need; p++; used++;
      end
    end
    noff = p;
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int m, g, noff, bud, rg;
    string t;
    rst_n = 1'b0;
    drive(0, 0, 63, 63, 63, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11", "state", int'(stage_state), 0);
    chk("R11", "stall", int'(stall_dec), 0);
    chk("R11", "err", int'(skid_err), 0);
    chk("R11", "fwd", int'(fwd_mask), 0);
    step();

    // Sweep: group size x kill pattern x credit x register pool
    for (int c = 1; c <= 4; c++) begin
      for (int k = 0; k < 16; k++) begin
        for (int b = -1; b <= 5; b++) begin
          for (int ri = 0; ri <= 5; ri++) begin
            rg = (ri == 5) ? 63 : ri;
            bud = b;
            drive(c, k, 4 + b, 63, rg, 0, 0);
            #1;
            expect_walk(c, k, bud, rg, 0, m, g, noff);
            t = (b <= 0) ? "R1" : (k != 0) ? "R3" : (rg < 63) ? "R4" : "R2";
            chk(t, "mask", int'(fwd_mask), m);
            chk("R4", "grant", int'(reg_grant), g);
            step();
            chk("R5", "state", int'(stage_state), (noff == c) ? 0 : 1);
            chk("R5", "stall", int'(stall_dec), (noff == c) ? 0 : 1);
            drive(0, 0, 63, 63, 63, 0, 1);
            step();
          end
        end
      end
    end

    // Leave Squashing
    drive(0, 0, 63, 63, 63, 0, 0);
    step();
    chk("R9", "state after squash", int'(stage_state), 0);

    // Partial group resumed from skid offset
    drive(4, 0, 6, 63, 63, 0, 0);
    #1;
    chk("R1", "rob budget 2 mask", int'(fwd_mask), 3);
    chk("R4", "grant", int'(reg_grant), 3);
    step();
    chk("R5", "blocked", int'(stage_state), 1);
    chk("R5", "stall", int'(stall_dec), 1);
    drive(0, 0, 63, 63, 63, 0, 0);
    #1;
    chk("R7", "no fwd while blocked", int'(fwd_mask), 0);
    step();
    chk("R7", "unblocking", int'(stage_state), 2);
    #1;
    chk("R8", "resume mask", int'(fwd_mask), 12);
    chk("R8", "resume grant", int'(reg_grant), 1);
    chk("R8", "from skid", int'(fwd_from_skid), 1);
    step();
    chk("R8", "back to running", int'(stage_state), 0);
    chk("R5", "stall low", int'(stall_dec), 0);

    // Down stall queues two groups, drained in order
    drive(3, 0, 63, 63, 63, 1, 0);
    #1;
    chk("R6", "no fwd under stall", int'(fwd_mask), 0);
    step();
    chk("R6", "blocked", int'(stage_state), 1);
    drive(2, 0, 63, 63, 63, 1, 0);
    step();
    drive(0, 0, 63, 63, 0, 0, 0);
    step();
    chk("R7", "held without registers", int'(stage_state), 1);
    drive(0, 0, 4, 63, 63, 0, 0);
    step();
    chk("R7", "held without credit", int'(stage_state), 1);
    drive(0, 0, 63, 63, 63, 0, 0);
    step();
    chk("R7", "unblocking", int'(stage_state), 2);
    #1;
    chk("R8", "first group", int'(fwd_mask), 7);
    chk("R8", "first grant", int'(reg_grant), 3);
    step();
    chk("R8", "still unblocking", int'(stage_state), 2);
    chk("R5", "stall kept", int'(stall_dec), 1);
    #1;
    chk("R8", "second group", int'(fwd_mask), 3);
    step();
    chk("R8", "running", int'(stage_state), 0);

    // Register shortage inside Unblocking, down stall in Unblocking
    drive(4, 0, 63, 63, 63, 1, 0);
    step();
    drive(0, 0, 63, 63, 63, 0, 0);
    step();
    chk("R7", "unblocking", int'(stage_state), 2);
    drive(0, 0, 63, 63, 2, 0, 0);
    #1;
    chk("R4", "short mask", int'(fwd_mask), 1);
    chk("R4", "short grant", int'(reg_grant), 1);
    step();
    chk("R8", "partial back to blocked", int'(stage_state), 1);
    drive(0, 0, 63, 63, 63, 0, 0);
    step();
    drive(0, 0, 63, 63, 63, 1, 0);
    #1;
    chk("R8", "stall in unblocking", int'(fwd_mask), 0);
    step();
    chk("R8", "to blocked", int'(stage_state), 1);
    drive(0, 0, 63, 63, 63, 0, 0);
    step();
    #1;
    chk("R8", "resume at offset 1", int'(fwd_mask), 14);
    chk("R8", "resume grant", int'(reg_grant), 3);
    step();
    chk("R8", "running", int'(stage_state), 0);

    // Issue-queue limited budget
    drive(4, 0, 63, 5, 63, 0, 0);
    #1;
    chk("R1", "iq budget 1", int'(fwd_mask), 1);
    step();
    drive(0, 0, 63, 63, 63, 0, 1);
    step();

    // Overflow and squash
    drive(2, 0, 63, 63, 63, 1, 0);
    step();
    drive(2, 0, 63, 63, 63, 1, 0);
    step();
    chk("R10", "no error when filled", int'(skid_err), 0);
    drive(1, 0, 63, 63, 63, 1, 0);
    step();
    chk("R10", "overflow flag", int'(skid_err), 1);
    drive(0, 0, 63, 63, 63, 0, 1);
    #1;
    chk("R9", "no fwd on squash", int'(fwd_mask), 0);
    step();
    chk("R9", "squashing", int'(stage_state), 3);
    chk("R9", "stall low", int'(stall_dec), 0);
    chk("R10", "flag sticky", int'(skid_err), 1);
    drive(3, 0, 63, 63, 63, 0, 0);
    #1;
    chk("R9", "squashing acts as running", int'(fwd_mask), 7);
    step();
    chk("R9", "running", int'(stage_state), 0);
    drive(0, 0, 63, 63, 63, 1, 0);
    step();
    drive(0, 0, 63, 63, 63, 0, 0);
    step();
    chk("R7", "empty skid goes to running", int'(stage_state), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule